// File: doc/BRIEF.md
# UART Host Register and Command Interface

This block is the register front end of a byte-wide serial port. A host reaches it through a synchronous strobe bus. Only the low six bits of the address are decoded, so the register set repeats across any wider address window. Two mode registers share one offset. An internal pointer selects between them: a write loads the selected one and then moves the pointer to the second, and a command can return the pointer to the first.

A command byte holds three independent subfields: a miscellaneous action, a transmitter action and a receiver action. They take effect in that order within one write. The block holds the transmit holding byte and hands it to the serializer as a one-cycle pulse once the transmitter is enabled. It drives a receiver enable and a one-cycle flush strobe to a separate receive FIFO. It pops that FIFO when the data offset is read. Interrupt status is formed from the transmit and receive conditions and a delta-break flag, then masked by a host-written mask, to drive a single interrupt line.

Top module: `uart_host_regs`

## Requirements
- R1: After synchronous reset, the following hold. Status reads 0x08, with only the transmit-empty bit set. Both mode registers, interrupt status and interrupt mask read 0. `rx_en`, `irq` and `tx_valid` are low, and `rdata` is 0.
- R2: Only `addr[5:0]` is decoded. Reads map as follows: 0x00 returns the mode register selected by the pointer, 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 `baud_a` and 0x1C `baud_b`. Every other offset reads 0. Writes to 0x04, 0x10 and unmapped offsets change nothing.
- R3: A write to 0x00 loads the mode register selected by the pointer and then points at the second register. A read of 0x00 leaves the pointer where it is. Command misc code 1 points back at the first register.
- R4: Command bits [3:2] control the transmitter: 1 enables it, 2 disables it, and 0 or 3 leave it unchanged. Status bit 2 (TxRDY) equals the transmitter enable.
- R5: Command bits [1:0] control `rx_en` with the same encoding as R4.
- R6: Command bits [6:4] hold the misc code, and bit 7 is ignored. Code 2 clears `rx_en` and pulses `rx_flush` during the write cycle. Code 3 disables the transmitter, sets TxEMP and discards any held byte. Code 5 clears the delta-break flag. Other codes do nothing. The transmit and receive subfields of the same byte are applied after the misc action.
- R7: A write to 0x0C stores the byte and clears status bit 3 (TxEMP). While the transmitter is enabled and TxEMP is clear, `tx_valid` pulses for one cycle with the byte on `tx_data`, one cycle after the write or the enable, and TxEMP sets again.
- R8: Status bit 0 (RxRDY) follows `rx_nonempty`, bit 1 (FFULL) follows `rx_full`, and bits 7:4 read 0.
- R9: A read of 0x0C while `rx_nonempty` is high asserts `rx_pop` during the read-strobe cycle and returns `rx_head`. While the FIFO is empty, the same read returns 0 and does not pop.
- R10: Interrupt status is formed as follows. Bit 0 equals TxRDY. Bit 1 equals FFULL when mode register one bit 6 is set, and RxRDY otherwise. Bit 2 is the delta-break flag, set by `brk_evt`; a set and a code-5 clear in the same cycle leave it set. Bits 7:3 read 0.
- R11: A write to 0x14 loads the interrupt mask. `irq` is high exactly when interrupt status AND mask is nonzero.
- R12: `rdata` is registered. It changes in the cycle after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address, low 6 bits decoded |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| baud_a | input | 8 | First baud value, readable at 0x18 |
| baud_b | input | 8 | Second baud value, readable at 0x1C |
| rx_nonempty | input | 1 | Receive FIFO holds at least one byte |
| rx_full | input | 1 | Receive FIFO is full |
| rx_head | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_flush | output | 1 | Flush strobe to the receive FIFO |
| rx_en | output | 1 | Receiver enable |
| brk_evt | input | 1 | Break-change event pulse |
| tx_valid | output | 1 | One-cycle transmit byte pulse |
| tx_data | output | 8 | Byte handed to the serializer |

## Verification
The assertions assume a well-behaved host and FIFO. Read and write strobes are never raised together, and `rx_full` is only high while `rx_nonempty` is high. The bench keeps to both rules. It issues one bus operation at a time with idle cycles between them, and it draws the FIFO flags as a nonempty bit plus a full bit that is forced low when the FIFO is empty. Break events are pulsed alone, except in one directed case that overlaps a flag clear on purpose.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam int DEC_W    = 6;
    localparam int BYTE_W   = 8;
    localparam int NUM_MODE = 2;
    localparam int PTR_W    = $clog2(NUM_MODE);

    localparam logic [DEC_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [DEC_W-1:0] OFS_STAT  = 6'h04;
    localparam logic [DEC_W-1:0] OFS_CMD   = 6'h08;
    localparam logic [DEC_W-1:0] OFS_DATA  = 6'h0C;
    localparam logic [DEC_W-1:0] OFS_INT   = 6'h14;
    localparam logic [DEC_W-1:0] OFS_BAUDA = 6'h18;
    localparam logic [DEC_W-1:0] OFS_BAUDB = 6'h1C;

    // status bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FFULL = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;

    // mode register one bit choosing the receive interrupt source
    localparam int MODE_RXSEL = 6;

    typedef enum logic [1:0] {
        XF_NOP  = 2'd0,
        XF_ON   = 2'd1,
        XF_OFF  = 2'd2,
        XF_RSVD = 2'd3
    } xfer_cmd_e;

    typedef enum logic [2:0] {
        MC_NOP     = 3'd0,
        MC_PTR_RST = 3'd1,
        MC_RX_RST  = 3'd2,
        MC_TX_RST  = 3'd3,
        MC_ERR_RST = 3'd4,
        MC_BRK_CLR = 3'd5,
        MC_BRK_ON  = 3'd6,
        MC_BRK_OFF = 3'd7
    } misc_cmd_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

    function automatic cmd_act_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_act_t  a;
        misc_cmd_e m;
        xfer_cmd_e t;
        xfer_cmd_e r;
        m = misc_cmd_e'(b[6:4]);
        t = xfer_cmd_e'(b[3:2]);
        r = xfer_cmd_e'(b[1:0]);
        a.ptr_rst = (m == MC_PTR_RST);
        a.rx_rst  = (m == MC_RX_RST);
        a.tx_rst  = (m == MC_TX_RST);
        a.brk_clr = (m == MC_BRK_CLR);
        a.tx_on   = (t == XF_ON);
        a.tx_off  = (t == XF_OFF);
        a.rx_on   = (r == XF_ON);
        a.rx_off  = (r == XF_OFF);
        return a;
    endfunction

endpackage

// File: rtl/uht_cmd_dec.sv
module uht_cmd_dec
    import uart_host_pkg::*;
(
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_act_t          act
);
    cmd_act_t raw;

    always_comb begin
        raw = decode_cmd(cmd_byte);
        act = cmd_we ? raw : '0;
    end
endmodule

// File: rtl/uht_mode_bank.sv
module uht_mode_bank
    import uart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [BYTE_W-1:0] mode_wdata,
    input  logic              ptr_rst,
    output logic [BYTE_W-1:0] mode_sel,
    output logic [BYTE_W-1:0] mode_first
);
    logic [BYTE_W-1:0] regs_q [NUM_MODE];
    logic [PTR_W-1:0]  ptr_q;

    for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (mode_we && ptr_q == PTR_W'(g))
                regs_q[g] <= mode_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (mode_we)
            ptr_q <= PTR_W'(NUM_MODE - 1);
        else if (ptr_rst)
            ptr_q <= '0;
    end

    assign mode_sel   = regs_q[ptr_q];
    assign mode_first = regs_q[0];

    p_mode_ptr_adv_r3: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (ptr_q == PTR_W'(NUM_MODE - 1)));
    p_mode_ptr_back_r3: assert property (@(posedge clk) disable iff (rst)
        (ptr_rst && !mode_we) |=> (ptr_q == '0));
endmodule

// File: rtl/uht_tx_hold.sv
module uht_tx_hold
    import uart_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              tx_rst,
    output logic              tx_en,
    output logic              tx_empty,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en    <= 1'b0;
            tx_empty <= 1'b1;
            tx_valid <= 1'b0;
            tx_data  <= '0;
            hold_q   <= '0;
        end else begin
            tx_valid <= 1'b0;
            // misc reset first, then the transmit subfield of the same byte
            if (tx_rst) tx_en <= 1'b0;
            if (tx_on)
                tx_en <= 1'b1;
            else if (tx_off)
                tx_en <= 1'b0;

            if (data_we) begin
                hold_q   <= data_in;
                tx_empty <= 1'b0;
            end else if (tx_rst) begin
                tx_empty <= 1'b1;
            end else if (tx_en && !tx_empty) begin
                tx_valid <= 1'b1;
                tx_data  <= hold_q;
                tx_empty <= 1'b1;
            end
        end
    end

    p_tx_pulse_empty_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> tx_empty);
    p_tx_single_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);
    p_tx_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !tx_empty);
    p_tx_enable_r4: assert property (@(posedge clk) disable iff (rst)
        tx_on |=> tx_en);
    p_tx_reset_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_rst && !tx_on && !data_we) |=> (!tx_en && tx_empty));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq,
    input  logic [7:0]        baud_a,
    input  logic [7:0]        baud_b,
    input  logic              rx_nonempty,
    input  logic              rx_full,
    input  logic [7:0]        rx_head,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              rx_en,
    input  logic              brk_evt,
    output logic              tx_valid,
    output logic [7:0]        tx_data
);
    logic [DEC_W-1:0]  ofs;
    cmd_act_t          act;
    logic [BYTE_W-1:0] mode_sel, mode_first;
    logic              tx_en_w, tx_empty_w;
    logic              brk_q;
    logic [BYTE_W-1:0] imr_q;
    logic [BYTE_W-1:0] status, isr, rd_mux;
    logic              sel_mode_w, sel_cmd_w, sel_data_w, sel_int_w;

    assign ofs        = addr[DEC_W-1:0];
    assign sel_mode_w = wr_en && (ofs == OFS_MODE);
    assign sel_cmd_w  = wr_en && (ofs == OFS_CMD);
    assign sel_data_w = wr_en && (ofs == OFS_DATA);
    assign sel_int_w  = wr_en && (ofs == OFS_INT);

    uht_cmd_dec u_dec (
        .cmd_we   (sel_cmd_w),
        .cmd_byte (wdata),
        .act      (act)
    );

    uht_mode_bank u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (sel_mode_w),
        .mode_wdata (wdata),
        .ptr_rst    (act.ptr_rst),
        .mode_sel   (mode_sel),
        .mode_first (mode_first)
    );

    uht_tx_hold u_tx (
        .clk      (clk),
        .rst      (rst),
        .data_we  (sel_data_w),
        .data_in  (wdata),
        .tx_on    (act.tx_on),
        .tx_off   (act.tx_off),
        .tx_rst   (act.tx_rst),
        .tx_en    (tx_en_w),
        .tx_empty (tx_empty_w),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    // receiver enable: misc reset, then receive subfield
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
        end else begin
            if (act.rx_rst) rx_en <= 1'b0;
            if (act.rx_on)
                rx_en <= 1'b1;
            else if (act.rx_off)
                rx_en <= 1'b0;
        end
    end
    assign rx_flush = act.rx_rst;

    // delta-break flag, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (rst)
            brk_q <= 1'b0;
        else if (brk_evt)
            brk_q <= 1'b1;
        else if (act.brk_clr)
            brk_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            imr_q <= '0;
        else if (sel_int_w)
            imr_q <= wdata;
    end

    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rx_nonempty;
        status[ST_FFULL] = rx_full;
        status[ST_TXRDY] = tx_en_w;
        status[ST_TXEMP] = tx_empty_w;

        isr         = '0;
        isr[IS_TX]  = tx_en_w;
        isr[IS_RX]  = mode_first[MODE_RXSEL] ? rx_full : rx_nonempty;
        isr[IS_BRK] = brk_q;
    end

    assign irq = |(isr & imr_q);

    always_comb begin
        case (ofs)
            OFS_MODE:  rd_mux = mode_sel;
            OFS_STAT:  rd_mux = status;
            OFS_DATA:  rd_mux = rx_nonempty ? rx_head : '0;
            OFS_INT:   rd_mux = isr;
            OFS_BAUDA: rd_mux = baud_a;
            OFS_BAUDB: rd_mux = baud_b;
            default:   rd_mux = '0;
        endcase
    end

    assign rx_pop = rd_en && (ofs == OFS_DATA) && rx_nonempty;

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    p_pop_guard_r9: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rx_nonempty && rd_en));
    p_flush_rx_off_r6: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (!rx_en || $past(wdata[1:0] == 2'b01)));
    p_brk_set_r10: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> isr[IS_BRK]);
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (imr_q != '0));
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_uart_host_regs.sv
module sim_uart_host_regs;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0, wr_en = 1'b0, brk_evt = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata, tx_data;
    logic       irq, rx_pop, rx_flush, rx_en, tx_valid;
    logic       rx_nonempty = 1'b0, rx_full = 1'b0;
    logic [7:0] rx_head = 8'h00;
    logic [7:0] baud_a = 8'hA5, baud_b = 8'h3C;

    always #(CLK_PER/2) clk = ~clk;

    uart_host_regs #(.ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .baud_a(baud_a),
        .baud_b(baud_b), .rx_nonempty(rx_nonempty), .rx_full(rx_full),
        .rx_head(rx_head), .rx_pop(rx_pop), .rx_flush(rx_flush),
        .rx_en(rx_en), .brk_evt(brk_evt), .tx_valid(tx_valid),
        .tx_data(tx_data)
    );

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    // bench model
    logic [7:0] m_mr0, m_mr1, m_imr, m_tb;
    bit         m_ptr, m_txen, m_txemp, m_rxen, m_dbrk;
    int         exp_txn = 0, got_txn = 0;
    logic [7:0] exp_txd = '0, got_txd = '0;

    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            got_txn = got_txn + 1;
            got_txd = tx_data;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {4'b0, m_txemp, m_txen, rx_full, rx_nonempty};
    endfunction

    function automatic logic [7:0] exp_isr();
        return {5'b0, m_dbrk, (m_mr0[6] ? rx_full : rx_nonempty), m_txen};
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a[5:0])
            6'h00:   return m_ptr ? m_mr1 : m_mr0;
            6'h04:   return exp_status();
            6'h0C:   return rx_nonempty ? rx_head : 8'h00;
            6'h14:   return exp_isr();
            6'h18:   return baud_a;
            6'h1C:   return baud_b;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_mr0 = 0; m_mr1 = 0; m_imr = 0; m_tb = 0;
        m_ptr = 0; m_txen = 0; m_txemp = 1; m_rxen = 0; m_dbrk = 0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d, output bit flush);
        flush = 0;
        case (a[5:0])
            6'h00: begin
                if (m_ptr) m_mr1 = d; else m_mr0 = d;
                m_ptr = 1;
            end
            6'h08: begin
                case (d[6:4])
                    3'd1: m_ptr = 0;
                    3'd2: begin m_rxen = 0; flush = 1; end
                    3'd3: begin m_txen = 0; m_txemp = 1; end
                    3'd5: m_dbrk = 0;
                    default: ;
                endcase
                if (d[3:2] == 2'd1) m_txen = 1;
                else if (d[3:2] == 2'd2) m_txen = 0;
                if (d[1:0] == 2'd1) m_rxen = 1;
                else if (d[1:0] == 2'd2) m_rxen = 0;
            end
            6'h0C: begin m_tb = d; m_txemp = 0; end
            6'h14: m_imr = d;
            default: ;
        endcase
        if (m_txen && !m_txemp) begin
            exp_txn++;
            exp_txd = m_tb;
            m_txemp = 1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        bit fl, exp_fl;
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        #(CLK_PER/4) fl = rx_flush;
        @(negedge clk);
        wr_en = 0;
        model_write(a, d, exp_fl);
        chk("R6 rx_flush strobe", {7'b0, fl}, {7'b0, exp_fl});
        idle(2);
    endtask

    task automatic bus_rd(input logic [7:0] a, input string tag);
        logic [7:0] exp;
        bit p, exp_p;
        exp   = exp_read(a);
        exp_p = (a[5:0] == 6'h0C) && rx_nonempty;
        @(negedge clk);
        rd_en = 1; addr = a;
        #(CLK_PER/4) p = rx_pop;
        @(negedge clk);
        rd_en = 0;
        chk(tag, rdata, exp);
        chk("R9 rx_pop strobe", {7'b0, p}, {7'b0, exp_p});
        idle(1);
        chk("R12 rdata holds", rdata, exp);
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R11 irq"}, {7'b0, irq}, {7'b0, |(exp_isr() & m_imr)});
        chk({tag, " R5 rx_en"}, {7'b0, rx_en}, {7'b0, m_rxen});
        chk({tag, " R7 tx count"}, 8'(got_txn), 8'(exp_txn));
        chk({tag, " R7 tx byte"}, got_txd, exp_txd);
    endtask

    task automatic set_fifo(input bit ne, input bit fu, input logic [7:0] h);
        @(negedge clk);
        rx_nonempty = ne; rx_full = ne & fu; rx_head = h;
        idle(1);
    endtask

    task automatic pulse_brk();
        @(negedge clk); brk_evt = 1;
        @(negedge clk); brk_evt = 0;
        m_dbrk = 1;
        idle(1);
    endtask

    function automatic logic [7:0] pick_ofs(input int k);
        case (k % 10)
            0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
            4: return 8'h10; 5: return 8'h14; 6: return 8'h18; 7: return 8'h1C;
            8: return 8'h20; default: return 8'h3C;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        idle(1);

        // R1 reset state
        chk("R1 rdata after reset", rdata, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        chk("R1 tx_valid after reset", {7'b0, tx_valid}, 8'h00);
        chk("R1 rx_en after reset", {7'b0, rx_en}, 8'h00);
        bus_rd(8'h04, "R1 status reset value");
        chk("R1 status literal", exp_status(), 8'h08);
        bus_rd(8'h00, "R1 mode reg reset");
        bus_rd(8'h14, "R1 isr reset");

        // R3 pointer behaviour
        bus_wr(8'h00, 8'h11);
        bus_wr(8'h00, 8'h22);
        bus_rd(8'h00, "R3 second mode reg");
        bus_rd(8'h00, "R3 read keeps pointer");
        bus_wr(8'h08, 8'h10);
        bus_rd(8'h00, "R3 pointer back to first");
        chk("R3 first mode literal", m_mr0, 8'h11);

        // R2 aliasing and baud values
        bus_rd(8'h58, "R2 baud_a alias");
        bus_rd(8'hDC, "R2 baud_b alias");
        bus_rd(8'h10, "R2 unmapped reads zero");
        bus_wr(8'h44, 8'hFF);
        bus_rd(8'h04, "R2 status write ignored");

        // R7 transmit held while disabled, sent on enable
        bus_wr(8'h0C, 8'h5A);
        bus_rd(8'h04, "R7 TxEMP clear while held");
        check_outputs("held");
        bus_wr(8'h08, 8'h04);
        check_outputs("R4 enable sends");
        bus_rd(8'h04, "R4 TxRDY set");
        bus_wr(8'h0C, 8'hC3);
        check_outputs("R7 direct send");

        // R6 tx reset discards held byte, enable in same byte applies after
        bus_wr(8'h08, 8'h08);
        bus_wr(8'h0C, 8'h77);
        bus_wr(8'h08, 8'h34);
        check_outputs("R6 tx reset then enable");
        bus_rd(8'h04, "R6 status after tx reset");

        // R5/R6 receiver
        bus_wr(8'h08, 8'h01);
        check_outputs("R5 rx on");
        bus_wr(8'h08, 8'hA1);
        check_outputs("R6 rx reset then enable");
        bus_wr(8'h08, 8'h20);
        check_outputs("R6 rx reset");

        // R8/R9/R10 with FIFO flags
        set_fifo(1, 0, 8'h9E);
        bus_wr(8'h14, 8'h02);
        check_outputs("R10 rxrdy source");
        bus_rd(8'h0C, "R9 pop head");
        bus_wr(8'h00, 8'h40);
        bus_wr(8'h08, 8'h10);
        bus_wr(8'h00, 8'h40);
        check_outputs("R10 ffull source not full");
        set_fifo(1, 1, 8'h01);
        check_outputs("R10 ffull source full");
        bus_rd(8'h14, "R10 isr full");
        set_fifo(0, 0, 8'hEE);
        bus_rd(8'h0C, "R9 empty reads zero");

        // R10 break flag, set wins over clear
        bus_wr(8'h14, 8'h04);
        pulse_brk();
        check_outputs("R10 break set");
        @(negedge clk);
        wr_en = 1; addr = 8'h08; wdata = 8'h50; brk_evt = 1;
        @(negedge clk);
        wr_en = 0; brk_evt = 0;
        idle(1);
        check_outputs("R10 set wins");
        bus_wr(8'h08, 8'h50);
        check_outputs("R10 break clear");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            a = {2'($urandom), 6'h00} | pick_ofs(int'($urandom));
            d = 8'($urandom);
            case (k)
                0, 1, 2: bus_rd(a, "R2 random read");
                3:       bus_wr(8'h08 | {2'($urandom), 6'h00}, d);
                4:       bus_wr(8'h0C, d);
                5:       bus_wr(a, d);
                6:       bus_wr(8'h14, d);
                7:       set_fifo(bit'($urandom), bit'($urandom), d);
                8:       pulse_brk();
                default: bus_wr(8'h00, d);
            endcase
            check_outputs("random");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule